// File: doc/BRIEF.md
# Four-Section I2C Line Engine

This block is the lowest layer of an I2C master. It turns single commands into bus cycles on two open-drain lines: a START condition, a STOP condition, one written data bit or one read data bit. Each command is built from four back-to-back time sections of equal length. The clock line may move only at the start of sections 1 and 3, and the data line only at the start of sections 2 and 4. A START or a STOP is a data-bit cycle whose section-4 data action has been swapped.

An upper layer hands over one command at a time through a valid/ready handshake. It assembles bytes from bits, decides on acknowledges and sequences transactions. It also supplies a 16-bit divider that sets how many system clocks each section lasts. When a command ends, the engine pulses `done` and, for a read, presents the bit it sampled while the clock was high. A slave that holds the clock low stretches the third section, because counting in that section starts only when the clock line reads back high.

Top module: `qsec_i2c_master`

## Requirements
- R1: After reset, `scl_oe` and `sda_oe` are 0 (both lines released), `cmd_ready` is 1 and `done` is 0.
- R2: A command accepted on a clock edge with `cmd_valid` and `cmd_ready` high produces a single-cycle `done` exactly 4*D cycles later, where D is the effective section length. `cmd_ready` stays low from the accepting edge until it rises together with `done`.
- R3: `scl_oe` goes to 1 on the accepting edge (section 1) and back to 0 exactly 2*D cycles later (section 3). It changes at no other time.
- R4: `sda_oe` changes only on the edge that starts section 2 (D cycles after acceptance) or section 4 (3*D cycles after acceptance, plus any stretch). Before section 2 it keeps the value it had at acceptance.
- R5: Command code 0 (START): the data line is released in section 2 and pulled low in section 4.
- R6: Command code 1 (STOP): the data line is pulled low in section 2 and released in section 4.
- R7: Command code 2 (write bit): `sda_oe` becomes the inverse of `cmd_bit` in section 2 and is not changed in section 4.
- R8: Command code 3 (read bit): the data line is released in section 2. `sda_in` is sampled at the end of section 3, and that value appears on `rd_bit` while `done` is high.
- R9: A divider value of 0 acts as 1, so a command then takes 4 cycles. The divider is captured when the command is accepted.
- R10: While `scl_in` reads low in section 3, the section counter does not advance. Every such cycle delays the start of section 4 and `done` by one cycle.
- R11: `cmd_valid` has no effect while `cmd_ready` is low. The running command keeps its timing, and no further command starts after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, can accept a command |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 write bit, 3 read bit |
| cmd_bit | input | 1 | Bit value for a write command |
| cmd_div | input | DIV_W | Section length in clocks (0 treated as 1) |
| scl_in | input | 1 | Clock line level read back |
| sda_in | input | 1 | Data line level read back |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| done | output | 1 | One-cycle pulse at the end of a command |
| rd_bit | output | 1 | Sampled data bit of the last read command |

## Verification
The assertions assume that the read-back clock line is low only while the engine pulls it, or while a slave stretches it after the engine has released it in section 3. They also assume that the environment drives the handshake inputs synchronously. The bench models both lines as wired-AND of the engine and a slave model. It asserts its stretch only while the engine already holds the clock low, and releases it a chosen number of cycles into section 3. The slave's data drive for a read is set while the clock is low, so the sampled value is well defined at the end of section 3.

// File: rtl/qsec_pkg.sv
package qsec_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    SEC_1 = 2'd0,
    SEC_2 = 2'd1,
    SEC_3 = 2'd2,
    SEC_4 = 2'd3
  } sec_e;

  typedef struct packed {
    logic chg;   // data line changes at entry of this section
    logic low;   // new value: 1 pulls the line low
  } sda_act_t;

  // Data-line action taken when entering a section
  function automatic sda_act_t sda_action(op_e op, logic wbit, sec_e sec);
    sda_act_t a;
    a.chg = 1'b0;
    a.low = 1'b0;
    if (sec == SEC_2) begin
      a.chg = 1'b1;
      unique case (op)
        OP_START: a.low = 1'b0;
        OP_STOP:  a.low = 1'b1;
        OP_WRITE: a.low = ~wbit;
        OP_READ:  a.low = 1'b0;
      endcase
    end else if (sec == SEC_4) begin
      unique case (op)
        OP_START: begin a.chg = 1'b1; a.low = 1'b1; end
        OP_STOP:  begin a.chg = 1'b1; a.low = 1'b0; end
        default:  begin a.chg = 1'b0; a.low = 1'b0; end
      endcase
    end
    return a;
  endfunction

endpackage

// File: rtl/qsec_section_timer.sv
module qsec_section_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  logic             tick,
  output logic             last
);
  logic [DIV_W-1:0] lim_q;
  logic [DIV_W-1:0] cnt_q;

  assign last = tick && (cnt_q == lim_q - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= DIV_W'(1);
      cnt_q <= '0;
    end else if (start) begin
      lim_q <= (div == '0) ? DIV_W'(1) : div;
      cnt_q <= '0;
    end else if (last) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/qsec_line_driver.sv
module qsec_line_driver (
  input  logic clk,
  input  logic rst,
  input  logic scl_load,
  input  logic scl_low,
  input  logic sda_load,
  input  logic sda_low,
  output logic scl_oe,
  output logic sda_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      if (scl_load) scl_oe <= scl_low;
      if (sda_load) sda_oe <= sda_low;
    end
  end
endmodule

// File: rtl/qsec_i2c_master.sv
module qsec_i2c_master
  import qsec_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_bit,
  input  logic [DIV_W-1:0] cmd_div,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             done,
  output logic             rd_bit
);
  logic     busy_q;
  sec_e     sec_q;
  sec_e     sec_nx;
  op_e      op_q;
  logic     bit_q;
  logic     rd_q;
  logic     done_q;
  logic     accept;
  logic     tick;
  logic     sec_end;
  sda_act_t act;

  assign accept = cmd_valid && !busy_q;
  // section 3 counts only once the clock line is seen high
  assign tick   = busy_q && ((sec_q != SEC_3) || scl_in);

  qsec_section_timer #(.DIV_W(DIV_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .start(accept),
    .div  (cmd_div),
    .tick (tick),
    .last (sec_end)
  );

  always_comb begin
    unique case (sec_q)
      SEC_1:   sec_nx = SEC_2;
      SEC_2:   sec_nx = SEC_3;
      SEC_3:   sec_nx = SEC_4;
      default: sec_nx = SEC_1;
    endcase
  end

  assign act = sda_action(op_q, bit_q, sec_nx);

  qsec_line_driver u_lines (
    .clk     (clk),
    .rst     (rst),
    .scl_load(accept || (sec_end && sec_q == SEC_2)),
    .scl_low (accept),
    .sda_load(sec_end && (sec_q != SEC_4) && act.chg),
    .sda_low (act.low),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      sec_q  <= SEC_1;
      op_q   <= OP_START;
      bit_q  <= 1'b0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        sec_q  <= SEC_1;
        op_q   <= op_e'(cmd_op);
        bit_q  <= cmd_bit;
        rd_q   <= 1'b0;
      end else if (sec_end) begin
        if (sec_q == SEC_3 && op_q == OP_READ) rd_q <= sda_in;
        if (sec_q == SEC_4) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          sec_q <= sec_nx;
        end
      end
    end
  end

  assign cmd_ready = !busy_q;
  assign done      = done_q;
  assign rd_bit    = rd_q;
endmodule

// File: rtl/qsec_i2c_master_chk.sv
module qsec_i2c_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       done,
  input logic       busy,
  input logic [1:0] sec
);
  // R2: done is a single-cycle pulse
  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2: ready is back when done is shown
  a_r2_done_ready: assert property (@(posedge clk) disable iff (rst)
    done |-> cmd_ready);

  // R3: clock line moves only when entering section 1 or 3
  a_r3_scl_window: assert property (@(posedge clk) disable iff (rst)
    !$stable(scl_oe) |-> (sec == 2'd0 || sec == 2'd2));

  // R3: clock held low through sections 1 and 2
  a_r3_scl_held: assert property (@(posedge clk) disable iff (rst)
    (busy && (sec == 2'd0 || sec == 2'd1)) |-> scl_oe);

  // R4: data line moves only when entering section 2 or 4
  a_r4_sda_window: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> (sec == 2'd1 || sec == 2'd3));

  // R11: an accepted command starts pulling the clock and drops ready
  a_r11_accept: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (!cmd_ready && scl_oe));
endmodule

bind qsec_i2c_master qsec_i2c_master_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .done     (done),
  .busy     (busy_q),
  .sec      (sec_q)
);

// File: tb/sim_qsec_i2c_master.sv
module sim_qsec_i2c_master;
  localparam int DIV_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = 2'd0;
  logic cmd_bit = 1'b0;
  logic [DIV_W-1:0] cmd_div = '0;
  logic scl_in, sda_in, scl_oe, sda_oe, done, rd_bit;
  logic stretch_hold = 1'b0;
  logic slave_pull = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  assign scl_in = ~(scl_oe | stretch_hold);
  assign sda_in = ~(sda_oe | slave_pull);

  qsec_i2c_master #(.DIV_W(DIV_W)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .cmd_div(cmd_div),
    .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done(done), .rd_bit(rd_bit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sda_s2(input int op, input logic b);
    case (op)
      0: return 1'b0;
      1: return 1'b1;
      2: return ~b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic sda_s4(input int op, input logic b);
    case (op)
      0: return 1'b1;
      1: return 1'b0;
      default: return sda_s2(op, b);
    endcase
  endfunction

  function automatic logic exp_sda(input int op, input logic b, input logic prev,
                                   input int k, input int d, input int s);
    if (k <= d) return prev;
    if (k <= 3*d + s) return sda_s2(op, b);
    return sda_s4(op, b);
  endfunction

  function automatic string op_tag(input int op);
    case (op)
      0: return "R4/R5 start";
      1: return "R4/R6 stop";
      2: return "R4/R7 write";
      default: return "R4/R8 read";
    endcase
  endfunction

  // Issue one command and follow it cycle by cycle
  task automatic run_cmd(input int op, input logic b, input int div, input int s,
                         input logic sbit, input bit junk);
    int d;
    int last;
    logic prev;
    int bad_scl, bad_sda, bad_rdy, bad_done;
    int rd_seen;
    d = (div == 0) ? 1 : div;
    last = 4*d + 1 + s;
    bad_scl = 0; bad_sda = 0; bad_rdy = 0; bad_done = 0; rd_seen = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    prev = sda_oe;
    cmd_valid = 1'b1;
    cmd_op = 2'(op);
    cmd_bit = b;
    cmd_div = DIV_W'(div);
    @(posedge clk);
    for (int k = 1; k <= last; k++) begin
      @(negedge clk);
      if (k == 1) begin
        cmd_valid = 1'b0;
        cmd_div = DIV_W'(($urandom % 7));
        slave_pull = (op == 3) ? ~sbit : 1'b0;
        if (s > 0) stretch_hold = 1'b1;
      end
      if (junk && k == 2) begin cmd_valid = 1'b1; cmd_op = 2'd1; end
      if (junk && k == 4*d - 1) cmd_valid = 1'b0;
      if (k == 2*d + 1 + s) stretch_hold = 1'b0;
      if (scl_oe !== (k <= 2*d)) bad_scl++;
      if (sda_oe !== exp_sda(op, b, prev, k, d, s)) bad_sda++;
      if (k < last) begin
        if (cmd_ready !== 1'b0) bad_rdy++;
        if (done !== 1'b0) bad_done++;
      end else begin
        if (cmd_ready !== 1'b1) bad_rdy++;
        if (done !== 1'b1) bad_done++;
        rd_seen = int'(rd_bit);
      end
    end
    slave_pull = 1'b0;
    check(bad_scl == 0, "R3 clock shape", bad_scl, 0);
    check(bad_sda == 0, op_tag(op), bad_sda, 0);
    check(bad_rdy == 0, (s > 0) ? "R10 ready timing" : "R2 ready timing", bad_rdy, 0);
    check(bad_done == 0, (div == 0) ? "R9 done timing" : "R2 done timing", bad_done, 0);
    if (op == 3) check(rd_seen == int'(sbit), "R8 read bit", rd_seen, int'(sbit));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(scl_oe == 1'b0, "R1 scl released", int'(scl_oe), 0);
    check(sda_oe == 1'b0, "R1 sda released", int'(sda_oe), 0);
    check(cmd_ready == 1'b1, "R1 ready", int'(cmd_ready), 1);
    check(done == 1'b0, "R1 done idle", int'(done), 0);

    // directed corners
    run_cmd(0, 1'b0, 2, 0, 1'b0, 0);     // R5
    run_cmd(2, 1'b1, 3, 0, 1'b0, 0);     // R7
    run_cmd(2, 1'b0, 3, 0, 1'b0, 0);     // R7
    run_cmd(3, 1'b0, 4, 0, 1'b1, 0);     // R8
    run_cmd(3, 1'b0, 4, 0, 1'b0, 0);     // R8
    run_cmd(1, 1'b0, 0, 0, 1'b0, 0);     // R6, R9
    run_cmd(0, 1'b0, 0, 0, 1'b0, 0);     // R9
    run_cmd(3, 1'b0, 37, 5, 1'b1, 0);    // R10 long stretch
    run_cmd(2, 1'b1, 5, 0, 1'b0, 1);     // R11 valid while busy
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(cmd_ready && !scl_oe, "R11 no extra command", int'(scl_oe), 0);
    end
    run_cmd(1, 1'b0, 1, 0, 1'b0, 0);

    // constrained random commands
    for (int i = 0; i < 150; i++) begin
      int op, div, s;
      op  = int'($urandom % 4);
      div = int'($urandom % 6);
      s   = (($urandom % 3) == 0) ? int'($urandom % 4) : 0;
      run_cmd(op, 1'($urandom), div, s, 1'($urandom), 0);
    end

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule